// File: doc/BRIEF.md
# Dual-Rate Machine-Cycle Enable Generator

This block turns one crystal-rate clock into the timing strobes that a small 8-bit controller core and its peripherals run on. It makes no derived clocks. Everything downstream stays on the crystal clock and advances only when one of three single-cycle enables is high. The phase enable marks each internal oscillator period. The machine-cycle strobe marks the last crystal period of each machine cycle. The time-base tick feeds the UART and timer prescalers.

One bit in a special-function register picks the speed. In standard speed a machine cycle lasts 12 crystal periods and the internal oscillator runs at half the crystal rate. In double speed a machine cycle lasts 6 crystal periods and the internal oscillator runs at the crystal rate. Software writes the bit over a simple register bus and can read it back. A new setting does not take effect at once. It waits until the running machine cycle finishes, so no machine cycle is ever cut short or stretched. The peripheral tick is derived from machine cycles, so every peripheral rate doubles in double speed.

Top module: `ckgen_top`

## Requirements
- R1: A synchronous active-high reset selects standard speed, makes the register read back 0 and clears all counters. While reset is high, all three enables are low. After reset is released, the first machine-cycle strobe is high in the cycle that follows the 11th rising edge at which reset is low. This completes a first machine cycle of 12 crystal periods.
- R2: In standard speed, the machine-cycle strobe is high for exactly one crystal cycle in every 12.
- R3: In standard speed, the phase enable is high every second crystal cycle, 6 times per machine cycle. It is always high in the cycle where the machine-cycle strobe is high.
- R4: In double speed, the machine-cycle strobe is high once every 6 crystal cycles and the phase enable is high on every crystal cycle.
- R5: A write with `sfr_wr_en` high and `sfr_wr_addr` equal to 8Fh loads bit 0 of `sfr_wr_data` into the speed bit (1 = double speed, 0 = standard). When `sfr_rd_addr` equals 8Fh, `sfr_rd_data` shows the speed bit in bit 0 in the same cycle, with no clock edge needed.
- R6: Writes to any other address, and writes with `sfr_wr_en` low, do not change the speed bit. Data bits 7..1 of a write are ignored. Read data bits 7..1 are always 0, and a read of any other address returns 00h.
- R7: A change of the speed bit takes effect only at a machine-cycle boundary. The machine cycle that is running when the write happens keeps its old length. A write captured at the rising edge that ends a strobe cycle takes effect at the following boundary. If the bit is written several times within one machine cycle, only the value held at the boundary counts.
- R8: The time-base tick is high once every 4 machine cycles, always in a cycle where the machine-cycle strobe is also high. Its period is therefore 48 crystal cycles in standard speed and 24 in double speed.
- R9: Every machine cycle is exactly 12 or exactly 6 crystal periods long, matching the speed in force when that cycle began. No machine cycle of any other length ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| sfr_wr_en | input | 1 | Register write strobe |
| sfr_wr_addr | input | 8 | Register write address |
| sfr_wr_data | input | 8 | Register write data |
| sfr_rd_addr | input | 8 | Register read address |
| sfr_rd_data | output | 8 | Register read data, combinational |
| phase_en | output | 1 | Internal oscillator period enable |
| mcyc_en | output | 1 | Machine-cycle strobe, last crystal period of each machine cycle |
| tick_en | output | 1 | Peripheral time-base tick |

## Verification
The active speed is held inside the sequencer, apart from the speed bit that software reads back. If it is wrong, or if it is committed at the wrong time, the fault shows at the ports as a strobe interval of the wrong length. The bench sees this within one machine cycle, 12 crystal periods at most. A wrong cycle counter shows up as a strobe spaced other than 6 or 12 periods apart, or as phase enables that fall out of step with the strobe, within one machine cycle. A prescaler fault in the time base only becomes visible at the next tick, up to 48 crystal periods later.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;

    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_X2  = 1'b1
    } ckmode_e;

    localparam int unsigned DEF_ADDR_W  = 8;
    localparam int unsigned DEF_DATA_W  = 8;
    localparam int unsigned DEF_CYC_STD = 12;
    localparam int unsigned DEF_TB_DIV  = 4;

endpackage

// File: rtl/ckgen_sfr.sv
module ckgen_sfr #(
    parameter int unsigned           ADDR_W   = 8,
    parameter int unsigned           DATA_W   = 8,
    parameter logic [ADDR_W-1:0]     SFR_ADDR = 8'h8F,
    parameter int unsigned           MODE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              mode_req
);

    typedef struct packed {
        logic speed;
    } sfr_t;

    sfr_t sfr_d, sfr_q;

    // Only the speed bit is stored; the reserved data bits go nowhere.
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_comb begin
        sfr_d = sfr_q;
        if (wr_en && (wr_addr == SFR_ADDR)) begin
            sfr_d.speed = wr_data[MODE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sfr_q <= '0;
        end else begin
            sfr_q <= sfr_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == SFR_ADDR) begin
            rd_data[MODE_BIT] = sfr_q.speed;
        end
    end

    assign mode_req = sfr_q.speed;

endmodule

// File: rtl/ckgen_seq.sv
module ckgen_seq
    import ckgen_pkg::*;
#(
    parameter int unsigned CYC_STD = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_req,
    output logic mode_x2,
    output logic phase_en,
    output logic mcyc_en
);

    localparam int unsigned CYC_X2 = CYC_STD / 2;
    localparam int unsigned CNT_W  = $clog2(CYC_STD);
    localparam logic [CNT_W-1:0] LAST_STD = CNT_W'(CYC_STD - 1);
    localparam logic [CNT_W-1:0] LAST_X2  = CNT_W'(CYC_X2 - 1);

    typedef struct packed {
        ckmode_e          mode;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic at_end;

    always_comb begin
        seq_d  = seq_q;
        at_end = (seq_q.cnt == ((seq_q.mode == MODE_X2) ? LAST_X2 : LAST_STD));
        if (at_end) begin
            // Boundary: restart the count and commit the requested speed.
            seq_d.cnt  = '0;
            seq_d.mode = ckmode_e'(mode_req);
        end else begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{mode: MODE_STD, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mcyc_en  = at_end;
    assign phase_en = (seq_q.mode == MODE_X2) ? 1'b1 : seq_q.cnt[0];
    assign mode_x2  = (seq_q.mode == MODE_X2);

endmodule

// File: rtl/ckgen_tbase.sv
module ckgen_tbase #(
    parameter int unsigned TB_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic mcyc_en,
    output logic tick_en
);

    localparam int unsigned TBW = (TB_DIV > 1) ? $clog2(TB_DIV) : 1;

    generate
        if (TB_DIV <= 1) begin : g_direct
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign tick_en        = mcyc_en;
        end else begin : g_prescale
            localparam logic [TBW-1:0] TB_LAST = TBW'(TB_DIV - 1);

            typedef struct packed {
                logic [TBW-1:0] div;
            } tb_t;

            tb_t tb_d, tb_q;
            logic wrap;

            always_comb begin
                tb_d = tb_q;
                wrap = mcyc_en && (tb_q.div == TB_LAST);
                if (mcyc_en) begin
                    tb_d.div = wrap ? '0 : tb_q.div + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    tb_q <= '0;
                end else begin
                    tb_q <= tb_d;
                end
            end

            assign tick_en = wrap;
        end
    endgenerate

endmodule

// File: rtl/ckgen_top.sv
module ckgen_top
    import ckgen_pkg::*;
#(
    parameter int unsigned       ADDR_W   = DEF_ADDR_W,
    parameter int unsigned       DATA_W   = DEF_DATA_W,
    parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h8F,
    parameter int unsigned       MODE_BIT = 0,
    parameter int unsigned       CYC_STD  = DEF_CYC_STD,
    parameter int unsigned       TB_DIV   = DEF_TB_DIV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sfr_wr_en,
    input  logic [ADDR_W-1:0] sfr_wr_addr,
    input  logic [DATA_W-1:0] sfr_wr_data,
    input  logic [ADDR_W-1:0] sfr_rd_addr,
    output logic [DATA_W-1:0] sfr_rd_data,
    output logic              phase_en,
    output logic              mcyc_en,
    output logic              tick_en
);

    logic mode_req;
    logic mode_x2;

    ckgen_sfr #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SFR_ADDR (SFR_ADDR),
        .MODE_BIT (MODE_BIT)
    ) u_sfr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (sfr_wr_en),
        .wr_addr  (sfr_wr_addr),
        .wr_data  (sfr_wr_data),
        .rd_addr  (sfr_rd_addr),
        .rd_data  (sfr_rd_data),
        .mode_req (mode_req)
    );

    ckgen_seq #(
        .CYC_STD (CYC_STD)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode_req (mode_req),
        .mode_x2  (mode_x2),
        .phase_en (phase_en),
        .mcyc_en  (mcyc_en)
    );

    ckgen_tbase #(
        .TB_DIV (TB_DIV)
    ) u_tbase (
        .clk     (clk),
        .rst     (rst),
        .mcyc_en (mcyc_en),
        .tick_en (tick_en)
    );

endmodule

// File: rtl/ckgen_chk.sv
module ckgen_chk #(
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h8F,
    parameter int unsigned       MODE_BIT = 0,
    parameter int unsigned       CYC_STD  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] sfr_rd_addr,
    input logic [DATA_W-1:0] sfr_rd_data,
    input logic              mode_x2,
    input logic              phase_en,
    input logic              mcyc_en,
    input logic              tick_en
);

    localparam int unsigned GW = $clog2(CYC_STD + 2);
    localparam logic [GW-1:0] LEN_STD = GW'(CYC_STD);
    localparam logic [GW-1:0] LEN_X2  = GW'(CYC_STD / 2);
    localparam logic [GW-1:0] GAP_MAX = {GW{1'b1}};
    localparam logic [DATA_W-1:0] KEEP = DATA_W'(1) << MODE_BIT;

    logic [GW-1:0] age;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
            gap <= GW'(1);
        end else begin
            if (age != GAP_MAX) age <= age + 1'b1;
            if (mcyc_en)             gap <= GW'(1);
            else if (gap != GAP_MAX) gap <= gap + 1'b1;
        end
    end

    a_r1_no_early_strobe: assert property (@(posedge clk) disable iff (rst)
        (age < LEN_STD - 1'b1) |-> !mcyc_en);

    a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
        mcyc_en |=> !mcyc_en);

    a_r3_phase_at_strobe: assert property (@(posedge clk) disable iff (rst)
        mcyc_en |-> phase_en);

    a_r3_std_phase_gap: assert property (@(posedge clk) disable iff (rst)
        (!mode_x2 && phase_en && !mcyc_en) |=> !phase_en);

    a_r7_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !mcyc_en |=> $stable(mode_x2));

    a_r8_tick_on_strobe: assert property (@(posedge clk) disable iff (rst)
        tick_en |-> mcyc_en);

    a_r9_len_matches_mode: assert property (@(posedge clk) disable iff (rst)
        mcyc_en |-> (gap == (mode_x2 ? LEN_X2 : LEN_STD)));

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (sfr_rd_data & ~KEEP) == '0);

    a_r6_other_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (sfr_rd_addr != SFR_ADDR) |-> (sfr_rd_data == '0));

endmodule

bind ckgen_top ckgen_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SFR_ADDR (SFR_ADDR),
    .MODE_BIT (MODE_BIT),
    .CYC_STD  (CYC_STD)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sfr_rd_addr (sfr_rd_addr),
    .sfr_rd_data (sfr_rd_data),
    .mode_x2     (mode_x2),
    .phase_en    (phase_en),
    .mcyc_en     (mcyc_en),
    .tick_en     (tick_en)
);

// File: tb/tb_ckgen_top.sv
`timescale 1ns/1ps
module tb_ckgen_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sfr_wr_en = 1'b0;
    logic [7:0] sfr_wr_addr = 8'h00;
    logic [7:0] sfr_wr_data = 8'h00;
    logic [7:0] sfr_rd_addr = 8'h8F;
    logic [7:0] sfr_rd_data;
    logic       phase_en;
    logic       mcyc_en;
    logic       tick_en;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ckgen_top dut (
        .clk         (clk),
        .rst         (rst),
        .sfr_wr_en   (sfr_wr_en),
        .sfr_wr_addr (sfr_wr_addr),
        .sfr_wr_data (sfr_wr_data),
        .sfr_rd_addr (sfr_rd_addr),
        .sfr_rd_data (sfr_rd_data),
        .phase_en    (phase_en),
        .mcyc_en     (mcyc_en),
        .tick_en     (tick_en)
    );

    typedef struct packed {
        logic       wen;
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] rd;
        logic [7:0] old_len;
        logic [7:0] new_len;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h8F, 8'h01, 8'h01, 8'd12, 8'd6 },
        '{1'b1, 8'h8F, 8'hFF, 8'h01, 8'd6,  8'd6 },
        '{1'b1, 8'h8E, 8'h00, 8'h01, 8'd6,  8'd6 },
        '{1'b1, 8'h8F, 8'hFE, 8'h00, 8'd6,  8'd12},
        '{1'b1, 8'h90, 8'h01, 8'h00, 8'd12, 8'd12},
        '{1'b0, 8'h8F, 8'h01, 8'h00, 8'd12, 8'd12},
        '{1'b1, 8'h8F, 8'h03, 8'h01, 8'd12, 8'd6 },
        '{1'b1, 8'h8F, 8'h00, 8'h00, 8'd6,  8'd12}
    };

    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    task automatic wait_mcyc();
        do @(negedge clk); while (!mcyc_en);
    endtask

    task automatic count_to_mcyc(output int n, output int ph);
        n = 0;
        ph = 0;
        do begin
            @(negedge clk);
            n++;
            if (phase_en) ph++;
        end while (!mcyc_en);
    endtask

    task automatic count_to_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_en);
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_wr_en   = 1'b1;
        sfr_wr_addr = a;
        sfr_wr_data = d;
        @(negedge clk);
        sfr_wr_en   = 1'b0;
    endtask

    task automatic reset_and_first(input string tag);
        int n;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({tag, " R1 strobe low in reset"}, int'(mcyc_en), 0);
        chk({tag, " R1 phase low in reset"}, int'(phase_en), 0);
        chk({tag, " R1 tick low in reset"}, int'(tick_en), 0);
        sfr_rd_addr = 8'h8F;
        #0.5;
        chk({tag, " R1 speed bit cleared"}, int'(sfr_rd_data), 0);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!mcyc_en && n < 40);
        chk({tag, " R1 first strobe edge count"}, n, 11);
    endtask

    initial begin : watchdog
        #400000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin : stim
        int n, ph, n2;
        reset_and_first("start");

        // Table walk: each write lands in a strobe cycle (R7 boundary case).
        for (int i = 0; i < NVEC; i++) begin
            wait_mcyc();
            sfr_wr_en   = VECS[i].wen;
            sfr_wr_addr = VECS[i].addr;
            sfr_wr_data = VECS[i].data;
            @(negedge clk);
            sfr_wr_en = 1'b0;
            n = 1;
            while (!mcyc_en) begin
                @(negedge clk);
                n++;
            end
            chk($sformatf("R7 vec%0d cycle after write keeps old length", i), n, int'(VECS[i].old_len));
            count_to_mcyc(n, ph);
            chk($sformatf("R2/R4/R9 vec%0d new cycle length", i), n, int'(VECS[i].new_len));
            chk($sformatf("R3/R4 vec%0d phases per cycle", i), ph, 6);
            sfr_rd_addr = 8'h8F;
            #0.5;
            chk($sformatf("R5/R6 vec%0d readback", i), int'(sfr_rd_data), int'(VECS[i].rd));
        end

        // R7: two writes in one machine cycle, last value (0) wins.
        wait_mcyc();
        @(negedge clk);
        sfr_write(8'h8F, 8'h01);
        sfr_write(8'h8F, 8'h00);
        wait_mcyc();
        count_to_mcyc(n, ph);
        chk("R7 toggled write leaves standard length", n, 12);

        // R8: time-base period in standard speed.
        wait_mcyc();
        do @(negedge clk); while (!tick_en);
        chk("R8 tick with strobe", int'(mcyc_en), 1);
        count_to_tick(n);
        chk("R8 tick period standard", n, 48);

        // R7: mid-cycle write; current cycle completes at 12, next is 6.
        wait_mcyc();
        repeat (3) @(negedge clk);
        sfr_write(8'h8F, 8'h01);
        n2 = 4;
        while (!mcyc_en) begin
            @(negedge clk);
            n2++;
        end
        chk("R7 mid-cycle write keeps old length", n2, 12);
        count_to_mcyc(n, ph);
        chk("R4 double-speed cycle length", n, 6);

        // R8: time-base period in double speed.
        do @(negedge clk); while (!tick_en);
        count_to_tick(n);
        chk("R8 tick period double speed", n, 24);
        chk("R8 tick with strobe", int'(mcyc_en), 1);

        // R4: phase every crystal cycle in double speed.
        ph = 0;
        repeat (5) begin
            @(negedge clk);
            if (phase_en) ph++;
        end
        chk("R4 phase every cycle", ph, 5);

        // R5/R6: combinational read decode.
        sfr_rd_addr = 8'h8E;
        #0.5;
        chk("R6 other read address returns zero", int'(sfr_rd_data), 0);
        sfr_rd_addr = 8'h8F;
        #0.5;
        chk("R5 same-cycle readback of speed bit", int'(sfr_rd_data), 1);

        // R1: reset from double speed returns to standard timing.
        reset_and_first("mid");
        count_to_mcyc(n, ph);
        chk("R1 standard length after reset", n, 12);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule